// File: doc/BRIEF.md
# DMA Descriptor Ring Sequencer

This block walks one DMA channel through a ring of 16-byte buffer descriptors kept in system memory. Starting at a programmed base pointer, it reads the four words of a descriptor through a word-wide memory port and checks the descriptor's valid flag. If the flag is set, it passes the source address, destination address and byte count to an external transfer engine and waits for the engine to finish. An external early-termination input can also end the transfer. The sequencer then writes the control word back with the valid flag cleared and moves to the next descriptor slot. After a descriptor marked as the ring's end, it returns to the base pointer.

A descriptor whose valid flag is clear parks the channel in idle and sets a sticky not-ready status. Software refills descriptors, sets their valid flags and then pulses the channel-enable input to restart. Restart begins at the parked descriptor.

Descriptor layout, byte offsets from the descriptor pointer:

- +0: source address.
- +4: byte count in bits 15:0.
- +8: destination address.
- +12: control word. Bit 15 is valid, bit 14 is end-of-frame, bit 13 is interrupt-request and bit 12 is ring-wrap.

Top module: `dma_ring_seq`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `chan_idle` is 1; `nrdy_status`, `mem_req`, `xfer_start`, `done_pulse` and `irq_pulse` are 0; the descriptor pointer equals `base_ptr`.
- R2: A descriptor is read as four word reads at pointer +0, +4, +8 and +12, in that order. The transfer byte count is bits 15:0 of word +4, and its upper bits are ignored.
- R3: When the fetched control word has bit 15 (valid) clear, the following happen: no transfer is started, the channel returns to idle, and `nrdy_status` is set.
- R4: When bit 15 is set, `xfer_start` pulses for exactly one cycle, with `xfer_src` = word +0, `xfer_dst` = word +8 and `xfer_len` = word +4 bits 15:0.
- R5: After each transfer, the sequencer writes one word to pointer +12. That word keeps control bits 14:12, and has bit 15 cleared and all other bits (including status bits 11:0) zero.
- R6: After the write-back, the next pointer is computed as follows. If bit 12 (wrap) is clear, it is the current pointer + 16. If bit 12 is set, it is `base_ptr`. Fetching then continues without software action.
- R7: `done_pulse` pulses once per descriptor, only when the buffer closed through `xfer_done` and bit 14 (end-of-frame) is set.
- R8: `irq_pulse` pulses on a normal close when bit 13 is set, or when bit 14 is set and `cmpl_irq_en` is 1. Bit 13 raises it regardless of `cmpl_irq_en`.
- R9: `ext_done` closes the buffer early. The descriptor is still written back and the pointer still advances, but neither `done_pulse` nor `irq_pulse` fires. `ext_done` wins over `xfer_done` when both are seen in the same cycle.
- R10: The channel leaves idle only on a `chan_en` pulse. `nrdy_status` stays set until `nrdy_clr` is 1. When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_ptr | input | AW | Ring base address, loaded at reset and on wrap |
| chan_en | input | 1 | Channel-enable strobe, resumes an idle channel |
| cmpl_irq_en | input | 1 | Raise interrupt on end-of-frame completion |
| nrdy_clr | input | 1 | Write-one-to-clear for the not-ready status |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed this cycle |
| xfer_start | output | 1 | One-cycle start strobe to the transfer engine |
| xfer_src | output | AW | Buffer source address |
| xfer_dst | output | AW | Buffer destination address |
| xfer_len | output | LW | Buffer byte count |
| xfer_done | input | 1 | Engine finished the byte count |
| ext_done | input | 1 | External early termination |
| done_pulse | output | 1 | Normal frame completion pulse |
| irq_pulse | output | 1 | Interrupt pulse |
| nrdy_status | output | 1 | Sticky buffer-not-ready status |
| chan_idle | output | 1 | Channel is parked idle |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the setting of the sticky not-ready bit on an invalid fetch and a software clear of it. The bench holds `nrdy_clr` high through an entire run that ends on an invalid descriptor, then drops the clear on the first cycle the channel reports idle. The status must read 1 afterwards. The second pair is `xfer_done` and `ext_done` arriving together. The model engine raises both in one cycle, and the scoreboard must see the write-back and the wrap to base with no completion or interrupt pulse.

// File: rtl/dring_pkg.sv
// Shared constants and state type for the descriptor ring sequencer.
// Assumes a 4-word descriptor of 32-bit words with byte addressing.
package dring_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_XFER,
        ST_WB,
        ST_NEXT
    } dr_state_t;

    localparam int DESC_WORDS = 4;
    localparam int STEP_BYTES = 16;
    localparam int W_SRC = 0;
    localparam int W_LEN = 1;
    localparam int W_DST = 2;
    localparam int W_CTL = 3;

    localparam int CTL_FULL = 15;
    localparam int CTL_LAST = 14;
    localparam int CTL_INTR = 13;
    localparam int CTL_WRAP = 12;
    localparam int CTL_RSVD_W = 12;
endpackage

// File: rtl/dring_ptr.sv
// Descriptor pointer register and word address generation.
// Loads the base on reset, steps by one descriptor or reloads the base on wrap.
// Assumes base_ptr is stable whenever a load can happen.
module dring_ptr #(
    parameter int AW = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_ptr,
    input  logic          advance,
    input  logic          wrap,
    input  logic [IW-1:0] word_sel,
    output logic [AW-1:0] desc_ptr,
    output logic [AW-1:0] word_addr
);
    import dring_pkg::*;

    logic [AW-1:0] cur_q;

    // Holds the current descriptor address, updated once per closed descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= base_ptr;
        end else if (advance) begin
            cur_q <= wrap ? base_ptr : cur_q + AW'(STEP_BYTES);
        end
    end

    // Byte address of the selected word inside the current descriptor.
    always_comb begin
        word_addr = cur_q + AW'({word_sel, 2'b00});
    end

    assign desc_ptr = cur_q;
endmodule

// File: rtl/dring_desc.sv
// Capture registers for the words of a fetched descriptor.
// One register per word, loaded when its index is acknowledged.
module dring_desc #(
    parameter int DW = 32,
    parameter int NW = 4,
    localparam int IW = $clog2(NW)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic [IW-1:0]         cap_idx,
    input  logic [DW-1:0]         cap_data,
    output logic [NW-1:0][DW-1:0] words
);
    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [DW-1:0] word_q;

        // Latches read data for this word slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (cap_en && cap_idx == IW'(g)) begin
                word_q <= cap_data;
            end
        end

        assign words[g] = word_q;
    end
endmodule

// File: rtl/dring_status.sv
// Sticky buffer-not-ready status with write-one-to-clear.
// A set in the same cycle as a clear takes priority.
module dring_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Sticky flag update: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_ring_seq.sv
// Descriptor ring sequencer for one DMA channel.
// Fetches 4-word descriptors, starts the transfer engine for valid ones,
// writes the control word back with the valid flag cleared and steps or
// wraps to the next slot. An invalid descriptor parks the channel idle.
// Assumes the memory port holds its request until mem_ack, and the engine
// returns xfer_done or ext_done once per xfer_start.
module dma_ring_seq #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_ptr,
    input  logic          chan_en,
    input  logic          cmpl_irq_en,
    input  logic          nrdy_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          xfer_start,
    output logic [AW-1:0] xfer_src,
    output logic [AW-1:0] xfer_dst,
    output logic [LW-1:0] xfer_len,
    input  logic          xfer_done,
    input  logic          ext_done,
    output logic          done_pulse,
    output logic          irq_pulse,
    output logic          nrdy_status,
    output logic          chan_idle
);
    import dring_pkg::*;

    localparam int IW = $clog2(DESC_WORDS);
    localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

    dr_state_t                    state_q;
    logic [IW-1:0]                widx_q;
    logic                         normal_q;
    logic [DESC_WORDS-1:0][DW-1:0] words;
    logic [DW-1:0]                ctl;
    logic [IW-1:0]                word_sel;
    logic [AW-1:0]                desc_ptr;
    logic                         cap_en;
    logic                         nrdy_set;
    logic                         desc_valid;
    logic                         desc_unused;

    // Sequencing of fetch, check, transfer, write-back and step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            widx_q   <= '0;
            normal_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (chan_en) begin
                        state_q <= ST_FETCH;
                        widx_q  <= '0;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (widx_q == LAST_IDX) begin
                            state_q <= ST_CHECK;
                        end else begin
                            widx_q <= widx_q + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    state_q <= desc_valid ? ST_XFER : ST_IDLE;
                end
                ST_XFER: begin
                    if (ext_done) begin
                        normal_q <= 1'b0;
                        state_q  <= ST_WB;
                    end else if (xfer_done) begin
                        normal_q <= 1'b1;
                        state_q  <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        state_q <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    state_q <= ST_FETCH;
                    widx_q  <= '0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Control word fields of the captured descriptor.
    assign ctl        = words[W_CTL];
    assign desc_valid = ctl[CTL_FULL];
    assign desc_unused = ^{words[W_LEN][DW-1:LW], ctl[DW-1:CTL_FULL+1],
                           ctl[CTL_RSVD_W-1:0], desc_ptr};

    // Memory port: word reads during fetch, one control write during write-back.
    always_comb begin
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_WB);
        mem_we    = (state_q == ST_WB);
        word_sel  = (state_q == ST_WB) ? IW'(W_CTL) : widx_q;
        mem_wdata = '0;
        mem_wdata[CTL_LAST] = ctl[CTL_LAST];
        mem_wdata[CTL_INTR] = ctl[CTL_INTR];
        mem_wdata[CTL_WRAP] = ctl[CTL_WRAP];
    end

    // Engine start and status strobes.
    always_comb begin
        cap_en     = (state_q == ST_FETCH) && mem_ack;
        xfer_start = (state_q == ST_CHECK) && desc_valid;
        nrdy_set   = (state_q == ST_CHECK) && !desc_valid;
        done_pulse = (state_q == ST_NEXT) && normal_q && ctl[CTL_LAST];
        irq_pulse  = (state_q == ST_NEXT) && normal_q &&
                     (ctl[CTL_INTR] || (ctl[CTL_LAST] && cmpl_irq_en));
        chan_idle  = (state_q == ST_IDLE);
    end

    assign xfer_src = words[W_SRC][AW-1:0];
    assign xfer_dst = words[W_DST][AW-1:0];
    assign xfer_len = words[W_LEN][LW-1:0];

    dring_ptr #(.AW(AW), .IW(IW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_ptr (base_ptr),
        .advance  (state_q == ST_NEXT),
        .wrap     (ctl[CTL_WRAP]),
        .word_sel (word_sel),
        .desc_ptr (desc_ptr),
        .word_addr(mem_addr)
    );

    dring_desc #(.DW(DW), .NW(DESC_WORDS)) u_desc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_idx (widx_q),
        .cap_data(mem_rdata),
        .words   (words)
    );

    dring_status u_nrdy (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (nrdy_set),
        .clr_i (nrdy_clr),
        .flag_o(nrdy_status)
    );
endmodule

// File: rtl/dring_checker.sv
// Protocol checks for the descriptor ring sequencer, bound to its top.
module dring_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_start,
    input logic          nrdy_status,
    input logic          nrdy_clr,
    input logic          chan_idle,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata,
    input logic          done_pulse
);
    import dring_pkg::*;

    // R4: start strobe lasts a single cycle.
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R10: not-ready status only drops under a clear request.
    assert_nrdy_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nrdy_status && !nrdy_clr) |=> nrdy_status);

    // R3: an idle channel neither starts transfers nor touches memory.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_idle |-> (!xfer_start && !mem_req));

    // R5: write-back never carries the valid flag or status bits.
    assert_wb_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (!mem_wdata[CTL_FULL] && mem_wdata[CTL_RSVD_W-1:0] == '0));

    // R7: completion comes between accesses, never while idle, and is single-cycle.
    assert_done_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!mem_req && !chan_idle));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
endmodule

bind dma_ring_seq dring_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .nrdy_status(nrdy_status),
    .nrdy_clr   (nrdy_clr),
    .chan_idle  (chan_idle),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .done_pulse (done_pulse)
);

// File: tb/dma_ring_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: scenario tasks push expected events, a monitor pops them.
module dma_ring_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_ptr = 32'h40;
    logic        chan_en = 1'b0;
    logic        cmpl_irq_en = 1'b0;
    logic        nrdy_clr = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xfer_start, xfer_done, ext_done;
    logic [31:0] xfer_src, xfer_dst;
    logic [15:0] xfer_len;
    logic        done_pulse, irq_pulse, nrdy_status, chan_idle;

    int checks = 0;
    int errors = 0;
    int eng_mode = 0;
    int eng_cnt;
    bit finished = 1'b0;
    logic [31:0] mem [0:63];

    typedef struct { int kind; logic [31:0] a; logic [31:0] b; logic [31:0] c; } ev_t;
    ev_t exp_q[$];

    always #2 clk = ~clk;

    dma_ring_seq uut (
        .clk(clk), .rst_n(rst_n), .base_ptr(base_ptr), .chan_en(chan_en),
        .cmpl_irq_en(cmpl_irq_en), .nrdy_clr(nrdy_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .ext_done(ext_done),
        .done_pulse(done_pulse), .irq_pulse(irq_pulse),
        .nrdy_status(nrdy_status), .chan_idle(chan_idle)
    );

    // Memory model: one-cycle registered acknowledge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[7:2]];
            mem_ack <= 1'b1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Engine model: ends a transfer three cycles after start (0 normal, 1 early, 2 both).
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        ext_done  <= 1'b0;
        if (!rst_n) begin
            eng_cnt <= 0;
        end else if (xfer_start) begin
            eng_cnt <= 3;
        end else if (eng_cnt == 1) begin
            eng_cnt <= 0;
            xfer_done <= (eng_mode != 1);
            ext_done  <= (eng_mode != 0);
        end else if (eng_cnt > 1) begin
            eng_cnt <= eng_cnt - 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pop_cmp(int kind, logic [31:0] a, logic [31:0] b, logic [31:0] c, string req);
        ev_t e;
        if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL %s unexpected event actual kind %0d expected none", req, kind);
        end else begin
            e = exp_q.pop_front();
            chk({req, " kind"}, 32'(kind), 32'(e.kind));
            chk({req, " a"}, a, e.a);
            chk({req, " b"}, b, e.b);
            chk({req, " c"}, c, e.c);
        end
    endtask

    // Monitor: compares each produced event with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (xfer_start) pop_cmp(1, xfer_src, xfer_dst, 32'(xfer_len), "R2/R4 start");
            if (mem_req && mem_we && mem_ack) pop_cmp(2, mem_addr, mem_wdata, 32'h0, "R5/R6 writeback");
            if (done_pulse) pop_cmp(3, 32'h0, 32'h0, 32'h0, "R7 done");
            if (irq_pulse) pop_cmp(4, 32'h0, 32'h0, 32'h0, "R8 irq");
        end
    end

    task automatic put_desc(int addr, logic [31:0] src, logic [31:0] len,
                            logic [31:0] dst, logic [31:0] ctl);
        mem[addr/4]     = src;
        mem[addr/4 + 1] = len;
        mem[addr/4 + 2] = dst;
        mem[addr/4 + 3] = ctl;
    endtask

    // Driver: expected events for one valid descriptor closed in the given mode.
    task automatic expect_desc(int addr, int mode, logic cen);
        logic [31:0] ctl = mem[addr/4 + 3];
        exp_q.push_back('{1, mem[addr/4], mem[addr/4 + 2], {16'h0, mem[addr/4 + 1][15:0]}});
        exp_q.push_back('{2, 32'(addr + 12), ctl & 32'h7000, 32'h0});
        if (mode == 0 && ctl[14]) exp_q.push_back('{3, 32'h0, 32'h0, 32'h0});
        if (mode == 0 && (ctl[13] || (ctl[14] && cen))) exp_q.push_back('{4, 32'h0, 32'h0, 32'h0});
    endtask

    task automatic kick_and_wait();
        @(negedge clk) chan_en = 1'b1;
        @(negedge clk) chan_en = 1'b0;
        while (!chan_idle) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[31] = 32'h0000_8000;   // valid slot at 0x70: fetched only if wrap fails
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 idle", 32'(chan_idle), 32'h1);
        chk("R1 nrdy", 32'(nrdy_status), 32'h0);
        chk("R1 mem_req", 32'(mem_req), 32'h0);
        chk("R1 start", 32'(xfer_start), 32'h0);
        chk("R1 done/irq", 32'({done_pulse, irq_pulse}), 32'h0);

        // Ring of three: plain, end+irq, end+wrap; then base is invalid (R3, R6).
        put_desc(32'h40, 32'h1000, 32'hDEAD_0020, 32'h2000, 32'h0000_8ABC);
        put_desc(32'h50, 32'h1100, 32'h0000_0008, 32'h2100, 32'h0000_E000);
        put_desc(32'h60, 32'h1200, 32'h0000_0010, 32'h2200, 32'h0000_D000);
        eng_mode = 0;
        expect_desc(32'h40, 0, 1'b0);
        expect_desc(32'h50, 0, 1'b0);
        expect_desc(32'h60, 0, 1'b0);
        kick_and_wait();
        chk("R3 nrdy after invalid", 32'(nrdy_status), 32'h1);
        chk("R6 ring fully consumed", 32'(exp_q.size()), 32'h0);
        chk("R5 status field zeroed", mem[19], 32'h0);

        // R10: clear, stays idle without enable.
        @(negedge clk) nrdy_clr = 1'b1;
        @(negedge clk) nrdy_clr = 1'b0;
        chk("R10 nrdy cleared", 32'(nrdy_status), 32'h0);
        repeat (5) @(negedge clk);
        chk("R10 stays idle", 32'(chan_idle), 32'h1);
        chk("R10 no memory activity", 32'(mem_req), 32'h0);

        // R9: early close on refilled base slot, no done/irq, advance to 0x50.
        mem[19] = 32'h0000_E000;
        eng_mode = 1;
        expect_desc(32'h40, 1, 1'b0);
        kick_and_wait();
        chk("R9 queue drained", 32'(exp_q.size()), 32'h0);
        chk("R9 parked on next slot", 32'(nrdy_status), 32'h1);

        // R8: end-of-frame interrupt through the enable input.
        @(negedge clk) nrdy_clr = 1'b1;
        @(negedge clk) nrdy_clr = 1'b0;
        mem[23] = 32'h0000_C000;
        cmpl_irq_en = 1'b1;
        eng_mode = 0;
        expect_desc(32'h50, 0, 1'b1);
        kick_and_wait();
        chk("R8 queue drained", 32'(exp_q.size()), 32'h0);
        cmpl_irq_en = 1'b0;

        // R9/R10: both dones together with wrap; clear held across the set.
        mem[27] = 32'h0000_F000;
        eng_mode = 2;
        expect_desc(32'h60, 2, 1'b0);
        @(negedge clk) nrdy_clr = 1'b1;
        kick_and_wait();
        nrdy_clr = 1'b0;
        @(negedge clk);
        chk("R10 set wins over clear", 32'(nrdy_status), 32'h1);
        chk("R9 both dones drained", 32'(exp_q.size()), 32'h0);
        chk("R6 wrap parks on base", mem[19], 32'h0000_6000);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule